// File: doc/BRIEF.md
# SAR Converter Serial Read Controller

This block is the host side of a 12-bit successive-approximation converter whose only control is an active-low chip select and a serial clock. A start request drops chip select, which wakes the converter, and keeps it low for a programmed wake interval. Raising chip select samples the analog input and starts the conversion. The controller then waits a short setup interval and runs a burst of 16 serial clocks. On each rising edge it captures one bit of the returned frame, which holds four leading zeros followed by twelve data bits, most significant bit first.

The twelve data bits are straight binary and go out unchanged. A flag beside them reports whether any of the four leading bits was non-zero. The result leaves through a valid/ready stream port. `res_valid_o` rises when a frame is complete and stays high, with data and flag frozen, until `res_ready_i` is high in the same cycle. While a result waits for acceptance the controller counts as busy and starts no new conversion, so back-pressure directly limits the conversion rate. The serial clock comes from the system clock through an equal-halves divider. Elaboration rejects any parameter set that breaks the converter's minimum wake time, its clock-to-select setup time or its serial clock frequency range.

Top module: `sar_serial_reader`

## Requirements
- R1: After reset, `adc_cs_n_o` is 1, `adc_sclk_o` is 1, `busy_o` and `res_valid_o` are 0, and `res_data_o` and `res_frame_err_o` are 0.
- R2: A `start_i` high while `busy_o` is low drives `adc_cs_n_o` low and `busy_o` high from the next cycle. Chip select then stays low for exactly WAKE_CYCLES system clocks before it returns high.
- R3: After `adc_cs_n_o` rises, `adc_sclk_o` stays high for at least SETUP_CYCLES system clocks before its first falling edge.
- R4: Each conversion produces exactly 16 serial clock low pulses. Each low phase lasts SCLK_HALF system clocks, and so does each high phase between pulses. The serial clock is high whenever no burst is running, including the whole time chip select is low.
- R5: `adc_sdata_i` is captured on each serial clock rising edge. Frame bit 15 comes first and bit 0 last, and frame bits 11..0 appear unchanged on `res_data_o`.
- R6: `res_frame_err_o` is 1 exactly when one or more of frame bits 15..12 is 1. The data bits are reported either way.
- R7: `res_valid_o` rises one cycle after the last serial clock rising edge. While `res_ready_i` is low it stays high, and `res_data_o` and `res_frame_err_o` stay stable. In the cycle after valid and ready are both high, `res_valid_o` and `busy_o` are 0.
- R8: A `start_i` high while `busy_o` is high has no effect. This covers the wake phase, the burst and a pending unaccepted result: no extra chip select pulse follows.
- R9: `res_data_o` and `res_frame_err_o` keep their value after acceptance and through the next conversion, until that conversion's result is presented.
- R10: `adc_cs_n_o` falls only in the cycle after an accepted start request. Each conversion has a single chip select low pulse, with no serial clock edge during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, taken only when idle |
| busy_o | output | 1 | Conversion running or result pending |
| res_data_o | output | 12 | Converted value, straight binary |
| res_frame_err_o | output | 1 | A leading frame bit was non-zero |
| res_valid_o | output | 1 | Result stream valid |
| res_ready_i | input | 1 | Result stream ready |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Converter serial clock, idles high |
| adc_sdata_i | input | 1 | Converter serial data |

## Verification
The hardest state to reach from the ports is a start request arriving while a finished result is still waiting behind a low `res_ready_i`. Here the controller is idle on the converter side, yet it must not begin a new frame. The bench holds ready low after a frame, pulses start several times while valid is held, and checks that chip select stays high and the held result stays unchanged. A converter model that replays a chosen 16-bit frame on serial clock falling edges provides the framing-error cases by placing ones among the leading bits.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAKE  = 3'd1,
    ST_SETUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sar_sclk_div.sv
module sar_sclk_div #(
  parameter int SCLK_HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCLK_HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_seq_ctl.sv
module sar_seq_ctl
  import sar_rd_pkg::*;
#(
  parameter int WAKE_CYCLES  = 200,
  parameter int SETUP_CYCLES = 4,
  parameter int FRAME_BITS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ready_i,
  input  logic tick_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic div_run_o,
  output logic clear_o,
  output logic shift_o,
  output logic last_o,
  output logic busy_o,
  output logic valid_o
);
  localparam int WAIT_MAX = (WAKE_CYCLES > SETUP_CYCLES) ? WAKE_CYCLES : SETUP_CYCLES;
  localparam int CW = $clog2(WAIT_MAX + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYCLES - 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYCLES - 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(FRAME_BITS - 1);

  seq_state_t st_q, st_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic sclk_q, sclk_d;

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    bcnt_d  = bcnt_q;
    sclk_d  = sclk_q;
    clear_o = 1'b0;
    shift_o = 1'b0;
    last_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        sclk_d = 1'b1;
        if (start_i) begin
          st_d    = ST_WAKE;
          wcnt_d  = '0;
          clear_o = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wcnt_q == WAKE_LAST) begin
          st_d   = ST_SETUP;
          wcnt_d = '0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_SETUP: begin
        if (wcnt_q == SETUP_LAST) begin
          st_d   = ST_SHIFT;
          bcnt_d = '0;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick_i) begin
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            shift_o = 1'b1;
            if (bcnt_q == BIT_LAST) begin
              last_o = 1'b1;
              st_d   = ST_DONE;
            end else begin
              bcnt_d = bcnt_q + 1'b1;
            end
          end
        end
      end
      ST_DONE: begin
        if (ready_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      bcnt_q <= '0;
      sclk_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      bcnt_q <= bcnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign cs_n_o    = (st_q != ST_WAKE);
  assign sclk_o    = sclk_q;
  assign div_run_o = (st_q == ST_SHIFT);
  assign busy_o    = (st_q != ST_IDLE);
  assign valid_o   = (st_q == ST_DONE);
endmodule

// File: rtl/sar_frame_cap.sv
module sar_frame_cap #(
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 shift_i,
  input  logic                 last_i,
  input  logic                 sdata_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 err_o
);
  localparam int LEAD_BITS = FRAME_BITS - DATA_BITS;

  logic [FRAME_BITS-2:0] sr_q;
  logic [FRAME_BITS-1:0] full;
  logic                  lead_bad;

  assign full = {sr_q, sdata_i};

  generate
    if (LEAD_BITS > 0) begin : g_lead
      assign lead_bad = |full[FRAME_BITS-1:DATA_BITS];
    end else begin : g_nolead
      assign lead_bad = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= full[FRAME_BITS-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      err_o  <= 1'b0;
    end else if (last_i) begin
      data_o <= full[DATA_BITS-1:0];
      err_o  <= lead_bad;
    end
  end
endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader #(
  parameter int CLK_MHZ      = 125,
  parameter int SCLK_HALF    = 8,
  parameter int WAKE_CYCLES  = 200,
  parameter int SETUP_CYCLES = 4,
  parameter int FRAME_BITS   = 16,
  parameter int DATA_BITS    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] res_data_o,
  output logic                 res_frame_err_o,
  output logic                 res_valid_o,
  input  logic                 res_ready_i,
  output logic                 adc_cs_n_o,
  output logic                 adc_sclk_o,
  input  logic                 adc_sdata_i
);
  localparam int WAKE_NS   = (WAKE_CYCLES * 1000) / CLK_MHZ;
  localparam int SETUP_NS  = (SETUP_CYCLES * 1000) / CLK_MHZ;
  localparam int SCLK_KHZ  = (CLK_MHZ * 1000) / (2 * SCLK_HALF);
  localparam bit PARAMS_OK = (WAKE_NS >= 1400) && (SETUP_NS >= 10) &&
                             (SCLK_KHZ >= 10) && (SCLK_KHZ <= 12000) &&
                             (SCLK_HALF >= 2) && (FRAME_BITS >= 2) &&
                             (DATA_BITS <= FRAME_BITS) && (SETUP_CYCLES >= 1);

  generate
    if (!PARAMS_OK) begin : g_bad_params
      $error("sar_serial_reader: timing parameters violate converter limits");
    end
  endgenerate

  logic tick, div_run, clear, shift, last;

  sar_sclk_div #(.SCLK_HALF(SCLK_HALF)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (div_run),
    .tick_o (tick)
  );

  sar_seq_ctl #(
    .WAKE_CYCLES  (WAKE_CYCLES),
    .SETUP_CYCLES (SETUP_CYCLES),
    .FRAME_BITS   (FRAME_BITS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_i   (res_ready_i),
    .tick_i    (tick),
    .cs_n_o    (adc_cs_n_o),
    .sclk_o    (adc_sclk_o),
    .div_run_o (div_run),
    .clear_o   (clear),
    .shift_o   (shift),
    .last_o    (last),
    .busy_o    (busy_o),
    .valid_o   (res_valid_o)
  );

  sar_frame_cap #(
    .FRAME_BITS (FRAME_BITS),
    .DATA_BITS  (DATA_BITS)
  ) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear),
    .shift_i (shift),
    .last_i  (last),
    .sdata_i (adc_sdata_i),
    .data_o  (res_data_o),
    .err_o   (res_frame_err_o)
  );
endmodule

// File: rtl/sar_serial_reader_chk.sv
module sar_serial_reader_chk #(
  parameter int SCLK_HALF    = 8,
  parameter int WAKE_CYCLES  = 200,
  parameter int SETUP_CYCLES = 4,
  parameter int DATA_BITS    = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 busy_o,
  input logic [DATA_BITS-1:0] res_data_o,
  input logic                 res_frame_err_o,
  input logic                 res_valid_o,
  input logic                 res_ready_i,
  input logic                 adc_cs_n_o,
  input logic                 adc_sclk_o
);
  logic [31:0] low_cs_cnt, high_cs_cnt, low_sclk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cs_cnt   <= '0;
      high_cs_cnt  <= '0;
      low_sclk_cnt <= '0;
    end else begin
      low_cs_cnt   <= adc_cs_n_o ? 32'd0 : low_cs_cnt + 32'd1;
      high_cs_cnt  <= !adc_cs_n_o ? 32'd0 :
                      ((&high_cs_cnt) ? high_cs_cnt : high_cs_cnt + 32'd1);
      low_sclk_cnt <= adc_sclk_o ? 32'd0 : low_sclk_cnt + 32'd1;
    end
  end

  // R2: chip select low window is exactly the wake count
  p_wake_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n_o) |-> (low_cs_cnt == WAKE_CYCLES));

  // R3: setup between chip select rising and any serial clock fall
  p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk_o) |-> (adc_cs_n_o && (high_cs_cnt >= SETUP_CYCLES)));

  // R4: each low phase has the programmed length
  p_low_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk_o) |-> (low_sclk_cnt == SCLK_HALF));

  // R7: held result stays put while the sink stalls
  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_data_o) && $stable(res_frame_err_o)));

  // R7: a valid result always counts as busy
  p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> busy_o);

  // R8 / R10: chip select falls only after an accepted request
  p_cs_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n_o) |-> $past(start_i && !busy_o));

  // R10: no serial clock activity while chip select is low
  p_sclk_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_cs_n_o |-> adc_sclk_o);
endmodule

bind sar_serial_reader sar_serial_reader_chk #(
  .SCLK_HALF    (SCLK_HALF),
  .WAKE_CYCLES  (WAKE_CYCLES),
  .SETUP_CYCLES (SETUP_CYCLES),
  .DATA_BITS    (DATA_BITS)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .busy_o          (busy_o),
  .res_data_o      (res_data_o),
  .res_frame_err_o (res_frame_err_o),
  .res_valid_o     (res_valid_o),
  .res_ready_i     (res_ready_i),
  .adc_cs_n_o      (adc_cs_n_o),
  .adc_sclk_o      (adc_sclk_o)
);

// File: tb/sim_sar_serial_reader.sv
`timescale 1ns/1ps
module sim_sar_serial_reader;
  localparam int HALF  = 8;
  localparam int WAKE  = 200;
  localparam int SETUP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ready = 1'b1;
  logic        busy, valid, ferr, cs_n, sclk;
  logic [11:0] data;
  logic        sdata = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] frame = 16'h0000;
  int nfall = 0;
  int bad_phase = 0;
  time tfall = 0;
  time trise = 0;

  always #4 clk = ~clk;

  sar_serial_reader u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
    .res_data_o(data), .res_frame_err_o(ferr), .res_valid_o(valid),
    .res_ready_i(ready), .adc_cs_n_o(cs_n), .adc_sclk_o(sclk),
    .adc_sdata_i(sdata)
  );

  // converter model: new bit after each serial clock fall
  always @(negedge cs_n or negedge sclk) begin
    if (!cs_n) begin
      nfall = 0;
    end else begin
      if (nfall > 0 && ($time - trise) != HALF * 8) bad_phase++;
      tfall = $time;
      if (nfall < 16) sdata = frame[15 - nfall];
      else sdata = 1'b0;
      nfall++;
    end
  end

  always @(posedge sclk) begin
    trise = $time;
    if (cs_n && nfall > 0 && ($time - tfall) != HALF * 8) bad_phase++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // one full conversion with ready held high; optional start pokes while busy
  task automatic run_conv(input logic [15:0] f, input bit poke);
    int n, s;
    bit got;
    frame = f;
    bad_phase = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!cs_n && busy, "R2 cs_n low and busy after start", {cs_n, busy}, 2'b01);
    n = 0;
    while (!cs_n && n < 5000) begin
      if (poke && n == 10) start = 1'b1;
      if (poke && n == 11) start = 1'b0;
      if (!sclk) s = -1;
      n++;
      @(negedge clk);
    end
    check(n == WAKE, "R2 chip select low length", n, WAKE);
    s = 0;
    while (sclk && s < 5000) begin s++; @(negedge clk); end
    check(s >= SETUP, "R3 setup before first sclk fall", s, SETUP);
    if (poke) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_valid(got);
    check(got, "R7 valid after frame", got, 1);
    check(nfall == 16, "R4 sclk pulses per frame", nfall, 16);
    check(bad_phase == 0, "R4 sclk half periods", bad_phase, 0);
    check(data == f[11:0], "R5 result bits", data, f[11:0]);
    check(ferr == (|f[15:12]), "R6 frame error flag", ferr, |f[15:12]);
    @(negedge clk);
    check(!valid && !busy, "R7 valid and busy drop after handshake", {valid, busy}, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !busy && !valid && data == 0 && !ferr,
          "R1 reset state", {cs_n, sclk, busy, valid, ferr, data}, {5'b11000, 12'h000});
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_patterns();
    run_conv(16'h0ABC, 1'b0);
    run_conv(16'h0FFF, 1'b0);
    run_conv(16'h0000, 1'b0);
    run_conv(16'h0801, 1'b0);
  endtask

  task automatic t_frame_err();
    run_conv(16'h8123, 1'b0);
    run_conv(16'h1001, 1'b0);
    run_conv(16'h0456, 1'b0);
  endtask

  task automatic t_start_busy();
    bit stray = 1'b0;
    run_conv(16'h0321, 1'b1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!cs_n || busy) stray = 1'b1;
    end
    check(!stray, "R8 start while busy ignored", stray, 0);
  endtask

  task automatic t_backpressure();
    bit got, moved = 1'b0, stray = 1'b0;
    ready = 1'b0;
    frame = 16'h0E5A;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_valid(got);
    check(got && data == 12'hE5A, "R5 result under stall", data, 12'hE5A);
    for (int i = 0; i < 30; i++) begin
      start = (i % 5 == 0);
      @(negedge clk);
      if (!valid || data != 12'hE5A) moved = 1'b1;
      if (!cs_n) stray = 1'b1;
    end
    start = 1'b0;
    check(!moved, "R7 valid and data held while ready low", moved, 0);
    check(!stray, "R8 start with pending result ignored", stray, 0);
    ready = 1'b1;
    @(negedge clk);
    check(!valid && !busy, "R7 handshake completes", {valid, busy}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!cs_n) stray = 1'b1;
    end
    check(!stray, "R10 no chip select pulse after stall", stray, 0);
  endtask

  task automatic t_hold();
    bit moved = 1'b0;
    bit got;
    run_conv(16'h0135, 1'b0);
    frame = 16'h4777;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 2000 && !valid; i++) begin
      if (data != 12'h135 || ferr) moved = 1'b1;
      @(negedge clk);
    end
    check(!moved, "R9 result held during next conversion", moved, 0);
    wait_valid(got);
    check(got && data == 12'h777 && ferr, "R9 new result replaces old", {ferr, data}, {1'b1, 12'h777});
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_frame_err();
    t_start_busy();
    t_backpressure();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule